// File: doc/BRIEF.md
# Pipelined Program Counter Unit

This block drives instruction fetch for a small 8-bit accumulator machine built as a three-stage fetch, decode and execute pipeline. It holds the fetch pointer into a 128-line program store, starts one new fetch every clock, and presents that pointer on an 8-bit address bus. The top bit is kept at zero so the store can grow later. A short line of registers carries each fetched address alongside its instruction, so the address of the instruction now in execute is always available. Software uses that value to build return addresses and relative targets in the accumulator.

Branches are predicted not taken. When the execute stage reports a taken branch, the unit raises a flush for that cycle and marks the two younger instructions invalid. On the next cycle it fetches from the new target. That target is either an absolute line number or the executing address plus a signed 8-bit offset. A branch that is not taken costs no cycles. A taken branch costs exactly two. A hold input freezes the whole sequence.

Top module: `pcu_fetch_unit`

## Requirements
- R1: While reset is asserted, fetch_addr is 0, and fetch_valid, exec_valid and flush are all 0.
- R2: On the first non-held edge after reset, fetch_valid becomes 1 with fetch_addr 0. After that, fetch_addr rises by one on every non-held edge unless a redirect occurs. It wraps from 127 to 0, and bit 7 of fetch_addr is always 0.
- R3: Whenever exec_valid is 1, exec_pc equals the fetch_addr value from two non-held cycles earlier, so valid exec_pc values follow the fetched order.
- R4: An absolute redirect (br_rel = 0) fetches next from br_arg[6:0]. Bit 7 of br_arg has no effect.
- R5: A relative redirect (br_rel = 1) fetches next from (exec_pc + br_arg) mod 128, with br_arg read as a two's-complement offset.
- R6: br_take with exec_valid = 1 and hold = 0 raises flush in that same cycle. exec_valid is then 0 for exactly the next two cycles, and the target reaches execute in the third cycle.
- R7: Without taken branches or hold, exec_valid stays at 1 in every cycle once the pipeline has filled.
- R8: br_take has no effect while exec_valid is 0. flush stays 0 and fetch continues in sequence.
- R9: While hold is 1, flush is 0 and fetch_addr, fetch_valid, exec_pc and exec_valid keep their values. A br_take that is still present when hold falls is then taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| hold | input | 1 | Freeze the fetch pointer and every pipeline stage |
| br_take | input | 1 | Branch in execute resolved as taken |
| br_rel | input | 1 | Redirect mode: 0 absolute, 1 relative to exec_pc |
| br_arg | input | 8 | Absolute line number, or signed relative offset |
| fetch_addr | output | 8 | Program store address; bit 7 is always 0 |
| fetch_valid | output | 1 | The fetch in progress holds a real instruction |
| flush | output | 1 | The fetch and decode contents are being discarded this cycle |
| exec_pc | output | 8 | Address of the instruction in execute |
| exec_valid | output | 1 | The instruction in execute is live |

## Verification
The bound checker watches the per-cycle rules on every cycle: sequential stepping and wrap, the zero top bit, and the redirect address for both modes. It also covers the two bubble cycles after a flush, the freeze under hold, flush suppression when execute is empty, and the two-cycle alignment of exec_pc. Only the bench scenarios can show whole-stream properties. These are that exactly the right instructions execute, in order, after absolute, forward-relative and backward-wrapping relative redirects. They also include that a redirect request made during a bubble is dropped, and that a branch held across a stall is taken once the stall lifts.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  // Program store depth is 2**PCU_ADDR_W lines
  localparam int PCU_ADDR_W = 7;
  // Width of the address and operand buses
  localparam int PCU_BUS_W  = 8;
  // Registers between fetch and execute
  localparam int PCU_LAG    = 2;

  typedef enum logic {
    TGT_ABS = 1'b0,
    TGT_REL = 1'b1
  } tgt_mode_e;

endpackage

// File: rtl/pcu_target_gen.sv
module pcu_target_gen
  import pcu_pkg::*;
#(
  parameter int ADDR_W = PCU_ADDR_W,
  parameter int BUS_W  = PCU_BUS_W
) (
  input  tgt_mode_e         mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [BUS_W-1:0]  operand,
  output logic [ADDR_W-1:0] target
);

  localparam int PAD_W = BUS_W - ADDR_W;

  logic [ADDR_W-1:0] abs_tgt;
  logic [ADDR_W-1:0] rel_tgt;

  // Truncating to ADDR_W bits yields the modulo result, so the sign of the
  // offset needs no explicit extension.
  always_comb begin
    abs_tgt = operand[ADDR_W-1:0];
    rel_tgt = ADDR_W'({{PAD_W{1'b0}}, base} + operand);
    case (mode)
      TGT_REL: target = rel_tgt;
      default: target = abs_tgt;
    endcase
  end

endmodule

// File: rtl/pcu_fetch_reg.sv
module pcu_fetch_reg #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] tgt,
  output logic [ADDR_W-1:0] pc,
  output logic              vld
);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic              v_q;
  logic              v_d;

  // Next state: the first advance after reset validates line 0 without
  // stepping; later advances step or load the redirect target.
  always_comb begin
    pc_d = pc_q;
    v_d  = v_q;
    if (adv) begin
      v_d = 1'b1;
      if (redirect) begin
        pc_d = tgt;
      end else if (v_q) begin
        pc_d = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      v_q  <= 1'b0;
    end else begin
      pc_q <= pc_d;
      v_q  <= v_d;
    end
  end

  assign pc  = pc_q;
  assign vld = v_q;

endmodule

// File: rtl/pcu_lag_line.sv
module pcu_lag_line #(
  parameter int ADDR_W = 7,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              kill,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic              in_vld,
  output logic [ADDR_W-1:0] out_pc,
  output logic              out_vld
);

  logic [ADDR_W-1:0] pc_q  [DEPTH];
  logic              v_q   [DEPTH];
  logic [ADDR_W-1:0] src_pc[DEPTH];
  logic              src_v [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign src_pc[i] = in_pc;
      assign src_v[i]  = in_vld;
    end else begin : g_tail
      assign src_pc[i] = pc_q[i-1];
      assign src_v[i]  = v_q[i-1];
    end

    logic [ADDR_W-1:0] pc_d;
    logic              v_d;

    // A kill empties every stage at once: each one holds a younger,
    // wrong-path instruction.
    always_comb begin
      pc_d = pc_q[i];
      v_d  = v_q[i];
      if (adv) begin
        pc_d = src_pc[i];
        v_d  = src_v[i] & ~kill;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[i] <= '0;
        v_q[i]  <= 1'b0;
      end else begin
        pc_q[i] <= pc_d;
        v_q[i]  <= v_d;
      end
    end
  end

  assign out_pc  = pc_q[DEPTH-1];
  assign out_vld = v_q[DEPTH-1];

endmodule

// File: rtl/pcu_fetch_unit.sv
module pcu_fetch_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W = PCU_ADDR_W,
  parameter int BUS_W  = PCU_BUS_W,
  parameter int LAG    = PCU_LAG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             br_take,
  input  logic             br_rel,
  input  logic [BUS_W-1:0] br_arg,
  output logic [BUS_W-1:0] fetch_addr,
  output logic             fetch_valid,
  output logic             flush,
  output logic [BUS_W-1:0] exec_pc,
  output logic             exec_valid
);

  localparam int PAD_W = BUS_W - ADDR_W;

  logic              advance;
  logic              redirect;
  logic [ADDR_W-1:0] f_pc;
  logic              f_vld;
  logic [ADDR_W-1:0] e_pc;
  logic              e_vld;
  logic [ADDR_W-1:0] tgt;
  tgt_mode_e         mode;

  assign advance  = ~hold;
  // Only a live instruction in execute may steer fetch, and only on an
  // edge at which the pipeline moves.
  assign redirect = br_take & e_vld & advance;
  assign mode     = br_rel ? TGT_REL : TGT_ABS;

  pcu_target_gen #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W)
  ) u_tgt (
    .mode    (mode),
    .base    (e_pc),
    .operand (br_arg),
    .target  (tgt)
  );

  pcu_fetch_reg #(
    .ADDR_W (ADDR_W)
  ) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (advance),
    .redirect (redirect),
    .tgt      (tgt),
    .pc       (f_pc),
    .vld      (f_vld)
  );

  pcu_lag_line #(
    .ADDR_W (ADDR_W),
    .DEPTH  (LAG)
  ) u_lag (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (advance),
    .kill    (redirect),
    .in_pc   (f_pc),
    .in_vld  (f_vld),
    .out_pc  (e_pc),
    .out_vld (e_vld)
  );

  assign fetch_addr  = {{PAD_W{1'b0}}, f_pc};
  assign fetch_valid = f_vld;
  assign flush       = redirect;
  assign exec_pc     = {{PAD_W{1'b0}}, e_pc};
  assign exec_valid  = e_vld;

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int ADDR_W = 7,
  parameter int BUS_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic             br_take,
  input logic             br_rel,
  input logic [BUS_W-1:0] br_arg,
  input logic [BUS_W-1:0] fetch_addr,
  input logic             fetch_valid,
  input logic             flush,
  input logic [BUS_W-1:0] exec_pc,
  input logic             exec_valid
);

  localparam int PAD_W = BUS_W - ADDR_W;

  logic [BUS_W-1:0] step_addr;
  logic [BUS_W-1:0] abs_addr;
  logic [BUS_W-1:0] rel_addr;

  always_comb begin
    step_addr = {{PAD_W{1'b0}}, ADDR_W'(fetch_addr[ADDR_W-1:0] + 1'b1)};
    abs_addr  = {{PAD_W{1'b0}}, br_arg[ADDR_W-1:0]};
    rel_addr  = {{PAD_W{1'b0}}, ADDR_W'(exec_pc[ADDR_W-1:0] + br_arg[ADDR_W-1:0])};
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (fetch_addr == '0) && !fetch_valid && !exec_valid && !flush); // R1

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr[BUS_W-1:ADDR_W] == '0); // R2

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !hold && !flush |=> fetch_addr == $past(step_addr)); // R2

  AST_EXEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid && $past(!hold) && $past(!hold, 2) |-> exec_pc == $past(fetch_addr, 2)); // R3

  AST_ABS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !br_rel |=> fetch_addr == $past(abs_addr) && fetch_valid); // R4

  AST_REL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    flush && br_rel |=> fetch_addr == $past(rel_addr) && fetch_valid); // R5

  AST_TAKE_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    br_take && exec_valid && !hold |-> flush); // R6

  AST_FIRST_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !exec_valid && !flush); // R6

  AST_SECOND_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |=> !exec_valid); // R6

  AST_EMPTY_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_valid |-> !flush); // R8

  AST_HOLD_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !flush); // R9

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(fetch_addr) && $stable(fetch_valid) &&
             $stable(exec_pc) && $stable(exec_valid)); // R9

endmodule

bind pcu_fetch_unit pcu_checker #(
  .ADDR_W (ADDR_W),
  .BUS_W  (BUS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold        (hold),
  .br_take     (br_take),
  .br_rel      (br_rel),
  .br_arg      (br_arg),
  .fetch_addr  (fetch_addr),
  .fetch_valid (fetch_valid),
  .flush       (flush),
  .exec_pc     (exec_pc),
  .exec_valid  (exec_valid)
);

// File: tb/tb_pcu_fetch_unit.sv
module tb_pcu_fetch_unit;

  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold = 1'b0;
  logic          br_take = 1'b0;
  logic          br_rel = 1'b0;
  logic [BW-1:0] br_arg = '0;
  logic [BW-1:0] fetch_addr;
  logic          fetch_valid;
  logic          flush;
  logic [BW-1:0] exec_pc;
  logic          exec_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  pcu_fetch_unit dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (hold),
    .br_take     (br_take),
    .br_rel      (br_rel),
    .br_arg      (br_arg),
    .fetch_addr  (fetch_addr),
    .fetch_valid (fetch_valid),
    .flush       (flush),
    .exec_pc     (exec_pc),
    .exec_valid  (exec_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver side of the scoreboard: queue the addresses expected to execute
  task automatic push_run(input int first, input int count);
    for (int k = 0; k < count; k++) exp_q.push_back((first + k) % 128);
  endtask

  // Advance until the given address is live in execute (sampled just after the edge)
  task automatic run_to(input int addr, input bit full);
    for (int n = 0; n < 400; n++) begin
      @(posedge clk); #1;
      if (full) check(exec_valid == 1'b1, "R7 no bubble", exec_valid, 1);
      if (exec_valid && exec_pc == addr) return;
    end
    check(1'b0, "run_to timeout", exec_pc, addr);
  endtask

  // Called in the cycle whose executing instruction is the branch
  task automatic take_jump(input bit rel, input logic [BW-1:0] arg, input int tgt,
                           input bit poke, input string req);
    br_take = 1'b1; br_rel = rel; br_arg = arg;
    #1 check(flush == 1'b1, "R6 flush on take", flush, 1);
    @(posedge clk); #1;
    check(fetch_addr == tgt, req, fetch_addr, tgt);
    check(fetch_valid == 1'b1, req, fetch_valid, 1);
    check(exec_valid == 1'b0, "R6 first bubble", exec_valid, 0);
    if (poke) begin
      br_take = 1'b1; br_rel = 1'b0; br_arg = 8'd99;
      #1 check(flush == 1'b0, "R8 request in bubble ignored", flush, 0);
    end else begin
      br_take = 1'b0;
    end
    @(posedge clk); #1;
    br_take = 1'b0;
    check(exec_valid == 1'b0, "R6 second bubble", exec_valid, 0);
    if (poke) check(fetch_addr == (tgt + 1) % 128, "R8 fetch stays sequential", fetch_addr, (tgt + 1) % 128);
    @(posedge clk); #1;
    check(exec_valid == 1'b1 && exec_pc == tgt, "R6 target in execute after two cycles", exec_pc, tgt);
  endtask

  // Monitor: pops the scoreboard and checks alignment against its own fetch history
  initial begin
    int h1;
    int h2;
    int depth;
    h1 = 0; h2 = 0; depth = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        depth = 0;
      end else begin
        if (exec_valid && depth >= 2)
          check(exec_pc == h2, "R3 exec aligned with fetch", exec_pc, h2);
        if (exec_valid && !hold) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected execute", exec_pc, -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            check(exec_pc == e, "R2 executed stream", exec_pc, e);
          end
        end
        if (!hold) begin
          h2 = h1;
          h1 = fetch_addr;
          if (depth < 2) depth++;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    logic [BW-1:0] frozen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fetch_addr == 0, "R1 reset address", fetch_addr, 0);
    check(fetch_valid == 1'b0, "R1 reset fetch_valid", fetch_valid, 0);
    check(exec_valid == 1'b0, "R1 reset exec_valid", exec_valid, 0);
    check(flush == 1'b0, "R1 reset flush", flush, 0);

    @(posedge clk); #1 rst_n = 1'b1;
    check(fetch_valid == 1'b0, "R1 idle after release", fetch_valid, 0);
    @(posedge clk); #1;
    check(fetch_valid == 1'b1 && fetch_addr == 0, "R2 first fetch at 0", fetch_addr, 0);
    @(posedge clk); #1;
    check(fetch_addr == 1, "R2 sequential step", fetch_addr, 1);

    // Straight-line run, then absolute jump with bit 7 set (R4) and a poke in the bubble (R8)
    push_run(0, 6);
    run_to(5, 1'b0);
    push_run(40, 5);
    take_jump(1'b0, 8'hA8, 40, 1'b1, "R4 absolute target ignores bit 7");
    run_to(44, 1'b1);

    // Forward relative: 44 + 10
    push_run(54, 3);
    take_jump(1'b1, 8'd10, 54, 1'b0, "R5 relative forward");
    run_to(56, 1'b1);

    // Backward relative with wrap: 56 - 60 = 124 mod 128
    push_run(124, 4);
    push_run(0, 3);
    take_jump(1'b1, 8'hC4, 124, 1'b0, "R5 relative backward wrap");
    run_to(127, 1'b1);
    check(fetch_addr == 1, "R2 wrap 127 to 0", fetch_addr, 1);
    run_to(2, 1'b1);

    // Hold with a pending branch: nothing moves, no flush (R9)
    hold = 1'b1; br_take = 1'b1; br_rel = 1'b1; br_arg = 8'd5;
    #1 check(flush == 1'b0, "R9 no flush under hold", flush, 0);
    frozen = fetch_addr;
    for (int c = 0; c < 2; c++) begin
      @(posedge clk); #1;
      check(fetch_addr == frozen, "R9 fetch frozen", fetch_addr, frozen);
      check(exec_valid == 1'b1 && exec_pc == 2, "R9 execute frozen", exec_pc, 2);
      check(flush == 1'b0, "R9 no flush under hold", flush, 0);
    end
    hold = 1'b0;
    push_run(7, 4);
    take_jump(1'b1, 8'd5, 7, 1'b0, "R5 relative after hold");
    run_to(10, 1'b1);

    @(posedge clk); #1 hold = 1'b1;
    repeat (3) @(posedge clk);
    #1 check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    report();
  end

endmodule